// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block schedules conversions for one shared converter on behalf of sixteen start-of-conversion slots. Each slot carries its own channel number, acquisition length, external trigger choice and an optional internal trigger taken from one of the sequencer's own interrupt lines. A trigger marks the slot pending. A state machine then serves pending slots one at a time in round-robin order. The converter itself is a fixed-latency engine: it samples the selected channel at the end of the acquisition window and holds the result in the slot's own result register a fixed number of cycles later.

Four interrupt lines each watch one chosen slot. Each line raises a flag and a one-cycle pulse when that slot's conversion ends, or, if selected, when its acquisition ends. Two of the lines can feed back into slot triggers. Pointing line 1 at slot 0 and line 2 at slot 15, with slots 1 to 15 triggered by line 1 and slot 0 by line 2, gives an endless chain that converts back to back after a single external trigger. Clearing slot 0's internal trigger selection ends the chain when the current round finishes. A trigger that hits a slot which is still pending sets that slot's sticky overflow flag and does not disturb the order of conversions.

The state machine has three states. ST_IDLE goes to ST_ACQ when any slot is pending, taking the granted slot. ST_ACQ counts down the acquisition window, then goes to ST_CONV and latches the sample. ST_CONV counts down the conversion latency, writes the result and goes back to ST_IDLE. Any other encoding falls back to ST_IDLE.

Top module: `conv_sequencer`

## Requirements
- R1: Each of the 16 slots uses its own channel and acquisition value A. A trigger sampled at clock edge T makes the slot's result register hold the sample of its channel at edge T+A+CONV+2, where CONV is the conversion latency parameter (default 11). The register keeps its old value at edge T+A+CONV+1. The acquisition window lasts A+1 cycles.
- R2: A slot's trigger is the OR of two inputs. The first is the external trigger input numbered by the slot's 3-bit trigger select. The second is the internal source chosen by its 2-bit internal select: 0 or 3 means none, 1 means interrupt line 1 (index 0) and 2 means interrupt line 2 (index 1). A trigger on an unselected input starts nothing.
- R3: A trigger for a slot that is already pending sets that slot's overflow flag. The flag stays set until a one is written to the matching bit of the overflow clear input. The slot still converts once, and the other slots keep their order.
- R4: The grant goes to the first pending slot after the most recently started slot, wrapping from 15 to 0. After reset, the scan starts at slot 0, so all 16 slots triggered together convert in order 0 to 15.
- R5: Each interrupt line has a 4-bit source slot select and an enable. When the source slot's end event occurs, the line's flag is set and the line gives a one-cycle pulse.
- R6: A line that is not in continuous mode does not fire while its flag is set. A line in continuous mode fires on every end event of its source slot.
- R7: With the late option set, the end event happens when the result is written, so the flag is visible at edge T+A+CONV+2. With the option clear, the end event happens at the end of acquisition, so the flag is visible at edge T+A+2.
- R8: Writing a one to a bit of the interrupt clear input clears that line's flag. Zero bits leave their flags unchanged. If a set and a clear reach a line in the same cycle, the set wins.
- R9: The busy output is high from edge T+1 until the result is written. The 4-bit busy slot output gives the number of the slot now converting, and it holds steady for the whole conversion.
- R10: With the chained configuration described above, one external trigger gives continuous rounds in order 0 to 15. Setting slot 0's internal select to none during a round stops the chain after slot 15 of that round.
- R11: After reset, busy, every interrupt flag and pulse, every overflow flag and every result register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_trig | input | 8 | External trigger inputs, one cycle high per event |
| cfg_chan | input | 64 | Per-slot channel number, 4 bits per slot, slot 0 in the low bits |
| cfg_acq | input | 144 | Per-slot acquisition value, 9 bits per slot |
| cfg_tsel | input | 48 | Per-slot external trigger select, 3 bits per slot |
| cfg_isel | input | 32 | Per-slot internal trigger select, 2 bits per slot |
| irq_src | input | 16 | Per-line source slot, 4 bits per line |
| irq_en | input | 4 | Per-line enable |
| irq_cont | input | 4 | Per-line continuous mode |
| irq_late | input | 1 | 1 = end event at result write, 0 = at end of acquisition |
| irq_clr | input | 4 | Write-one-to-clear strobe for the line flags |
| ovf_clr | input | 16 | Write-one-to-clear strobe for the overflow flags |
| samp_chan | output | 4 | Channel the converter is sampling |
| samp_data | input | 12 | Converter input value for samp_chan |
| result_bus | output | 192 | Per-slot result registers, 12 bits per slot |
| irq_flag | output | 4 | Interrupt line flags |
| irq_pulse | output | 4 | One-cycle interrupt pulses |
| ovf_flag | output | 16 | Per-slot overflow flags |
| busy | output | 1 | A conversion is in progress |
| busy_slot | output | 4 | Slot now converting |

## Verification
Every result follows from edge T, the edge at which the trigger is sampled. Busy and the busy slot appear at T+1. A late flag and the result register appear at T+A+CONV+2. An early flag appears at T+A+2. An overflow flag appears at the edge that samples the second trigger. The bench drives and samples on falling edges and counts them from the trigger. For the result and both flag timings it checks the cycle just before the due edge (old value) and the due cycle (new value), so a result that arrives one cycle early or late fails. Ordering, chaining and pulse counts come from a falling-edge monitor that logs each rising edge of busy together with the slot number.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACQ  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_t;

    localparam logic [1:0] ISEL_NONE  = 2'd0;
    localparam logic [1:0] ISEL_LINE1 = 2'd1;
    localparam logic [1:0] ISEL_LINE2 = 2'd2;
endpackage

// File: rtl/seq_rr_arbiter.sv
module seq_rr_arbiter #(
    parameter int N = 16,
    parameter int W = 4
) (
    input  logic [N-1:0] req,
    input  logic [W-1:0] last,
    output logic         valid,
    output logic [W-1:0] idx
);
    int pos;

    // scan from farthest to nearest so the nearest slot after 'last' wins
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        pos   = 0;
        for (int k = N; k >= 1; k--) begin
            pos = int'(last) + k;
            if (pos >= N) pos = pos - N;
            if (req[pos]) begin
                valid = 1'b1;
                idx   = W'(pos);
            end
        end
    end
endmodule

// File: rtl/seq_slot_bank.sv
module seq_slot_bank #(
    parameter int N      = 16,
    parameter int W      = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      trig,
    input  logic              start,
    input  logic [W-1:0]      start_idx,
    input  logic              wr_en,
    input  logic [W-1:0]      wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [N-1:0]      ovf_clr,
    output logic [N-1:0]      pending,
    output logic [N-1:0]      ovf,
    output logic [N*DATA_W-1:0] results
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        logic started;
        assign started = start && (start_idx == W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[i] <= 1'b0;
                ovf[i]     <= 1'b0;
                results[i*DATA_W +: DATA_W] <= '0;
            end else begin
                pending[i] <= (pending[i] && !started) || trig[i];
                if (trig[i] && pending[i] && !started)
                    ovf[i] <= 1'b1;
                else if (ovf_clr[i])
                    ovf[i] <= 1'b0;
                if (wr_en && (wr_idx == W'(i)))
                    results[i*DATA_W +: DATA_W] <= wr_data;
            end
        end

        p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[i] && !ovf_clr[i]) |=> ovf[i])
            else $error("overflow flag of slot %0d dropped without clear", i);
    end
endmodule

// File: rtl/seq_irq_line.sv
module seq_irq_line #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         cont,
    input  logic [W-1:0] src,
    input  logic         clr,
    input  logic         evt,
    input  logic [W-1:0] evt_slot,
    output logic         fire,
    output logic         flag,
    output logic         pulse
);
    assign fire = en && evt && (evt_slot == src) && (cont || !flag);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
            if (fire)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
        end
    end

    p_pulse_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> flag)
        else $error("interrupt pulse without flag");

    p_noncont_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cont && flag) |-> !fire)
        else $error("non-continuous line fired with flag set");
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
    parameter int NUM_SLOTS   = 16,
    parameter int CH_W        = 4,
    parameter int ACQ_W       = 9,
    parameter int DATA_W      = 12,
    parameter int NUM_EXT     = 8,
    parameter int NUM_LINES   = 4,
    parameter int CONV_CYCLES = 11,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int EXT_SEL_W  = $clog2(NUM_EXT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_EXT-1:0]          ext_trig,
    input  logic [NUM_SLOTS*CH_W-1:0]   cfg_chan,
    input  logic [NUM_SLOTS*ACQ_W-1:0]  cfg_acq,
    input  logic [NUM_SLOTS*EXT_SEL_W-1:0] cfg_tsel,
    input  logic [NUM_SLOTS*2-1:0]      cfg_isel,
    input  logic [NUM_LINES*SLOT_W-1:0] irq_src,
    input  logic [NUM_LINES-1:0]        irq_en,
    input  logic [NUM_LINES-1:0]        irq_cont,
    input  logic                        irq_late,
    input  logic [NUM_LINES-1:0]        irq_clr,
    input  logic [NUM_SLOTS-1:0]        ovf_clr,
    output logic [CH_W-1:0]             samp_chan,
    input  logic [DATA_W-1:0]           samp_data,
    output logic [NUM_SLOTS*DATA_W-1:0] result_bus,
    output logic [NUM_LINES-1:0]        irq_flag,
    output logic [NUM_LINES-1:0]        irq_pulse,
    output logic [NUM_SLOTS-1:0]        ovf_flag,
    output logic                        busy,
    output logic [SLOT_W-1:0]           busy_slot
);
    import seq_pkg::*;

    localparam int CONV_W = $clog2(CONV_CYCLES + 1);
    localparam int CNT_W  = (ACQ_W > CONV_W) ? ACQ_W : CONV_W;

    // per-slot configuration views
    logic [CH_W-1:0]      chan_a [NUM_SLOTS];
    logic [ACQ_W-1:0]     acq_a  [NUM_SLOTS];
    logic [EXT_SEL_W-1:0] tsel_a [NUM_SLOTS];
    logic [1:0]           isel_a [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cfg
        assign chan_a[i] = cfg_chan[i*CH_W +: CH_W];
        assign acq_a[i]  = cfg_acq[i*ACQ_W +: ACQ_W];
        assign tsel_a[i] = cfg_tsel[i*EXT_SEL_W +: EXT_SEL_W];
        assign isel_a[i] = cfg_isel[i*2 +: 2];
    end

    seq_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [SLOT_W-1:0] cur_q, cur_d;
    logic [SLOT_W-1:0] last_q, last_d;
    logic [DATA_W-1:0] samp_q, samp_d;
    logic              start, wr_en;

    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] trig;
    logic                 arb_valid;
    logic [SLOT_W-1:0]    arb_idx;
    logic [NUM_LINES-1:0] fire;
    logic                 evt;

    seq_rr_arbiter #(.N(NUM_SLOTS), .W(SLOT_W)) u_arb (
        .req   (pend),
        .last  (last_q),
        .valid (arb_valid),
        .idx   (arb_idx)
    );

    seq_slot_bank #(.N(NUM_SLOTS), .W(SLOT_W), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .start     (start),
        .start_idx (arb_idx),
        .wr_en     (wr_en),
        .wr_idx    (cur_q),
        .wr_data   (samp_q),
        .ovf_clr   (ovf_clr),
        .pending   (pend),
        .ovf       (ovf_flag),
        .results   (result_bus)
    );

    // end event: after acquisition (early) or at result write (late)
    always_comb begin
        if (irq_late)
            evt = (state_q == ST_CONV) && (cnt_q == '0);
        else
            evt = (state_q == ST_ACQ) && (cnt_q == '0);
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        seq_irq_line #(.W(SLOT_W)) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (irq_en[l]),
            .cont     (irq_cont[l]),
            .src      (irq_src[l*SLOT_W +: SLOT_W]),
            .clr      (irq_clr[l]),
            .evt      (evt),
            .evt_slot (cur_q),
            .fire     (fire[l]),
            .flag     (irq_flag[l]),
            .pulse    (irq_pulse[l])
        );
    end

    // slot trigger: external select OR chosen internal line
    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            trig[i] = ext_trig[tsel_a[i]];
            if (isel_a[i] == ISEL_LINE1) trig[i] = trig[i] | fire[0];
            if (isel_a[i] == ISEL_LINE2) trig[i] = trig[i] | fire[1];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cur_q   <= '0;
            last_q  <= SLOT_W'(NUM_SLOTS - 1);
            samp_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cur_q   <= cur_d;
            last_q  <= last_d;
            samp_q  <= samp_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cur_d   = cur_q;
        last_d  = last_q;
        samp_d  = samp_q;
        start   = 1'b0;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (arb_valid) begin
                    start   = 1'b1;
                    cur_d   = arb_idx;
                    last_d  = arb_idx;
                    cnt_d   = CNT_W'(acq_a[arb_idx]);
                    state_d = ST_ACQ;
                end
            end
            ST_ACQ: begin
                if (cnt_q == '0) begin
                    samp_d  = samp_data;
                    cnt_d   = CNT_W'(CONV_CYCLES - 1);
                    state_d = ST_CONV;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_CONV: begin
                if (cnt_q == '0) begin
                    wr_en   = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        busy_slot = cur_q;
        samp_chan = chan_a[cur_q];
    end

    p_slot_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACQ) |=> (busy_slot == $past(busy_slot)))
        else $error("busy slot changed during a conversion");

    p_grant_pending_r4: assert property (@(posedge clk) disable iff (!rst_n)
        arb_valid |-> pend[arb_idx])
        else $error("grant to a slot that is not pending");
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
    localparam int CONV = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]   ext_trig = '0;
    logic [63:0]  cfg_chan;
    logic [143:0] cfg_acq;
    logic [47:0]  cfg_tsel;
    logic [31:0]  cfg_isel;
    logic [15:0]  irq_src;
    logic [3:0]   irq_en = '0;
    logic [3:0]   irq_cont = '0;
    logic         irq_late = 1'b1;
    logic [3:0]   irq_clr = '0;
    logic [15:0]  ovf_clr = '0;
    logic [3:0]   samp_chan;
    logic [11:0]  samp_data;
    logic [191:0] result_bus;
    logic [3:0]   irq_flag, irq_pulse;
    logic [15:0]  ovf_flag;
    logic         busy;
    logic [3:0]   busy_slot;

    logic [3:0] b_chan [16];
    logic [8:0] b_acq  [16];
    logic [2:0] b_tsel [16];
    logic [1:0] b_isel [16];
    logic [3:0] b_src  [4];

    always_comb begin
        for (int i = 0; i < 16; i++) begin
            cfg_chan[i*4 +: 4] = b_chan[i];
            cfg_acq[i*9 +: 9]  = b_acq[i];
            cfg_tsel[i*3 +: 3] = b_tsel[i];
            cfg_isel[i*2 +: 2] = b_isel[i];
        end
        for (int l = 0; l < 4; l++) irq_src[l*4 +: 4] = b_src[l];
    end

    function automatic logic [11:0] fval(input logic [3:0] ch);
        return 12'(int'(ch) * 200 + 37);
    endfunction

    assign samp_data = fval(samp_chan);

    conv_sequencer #(.CONV_CYCLES(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig),
        .cfg_chan(cfg_chan), .cfg_acq(cfg_acq), .cfg_tsel(cfg_tsel), .cfg_isel(cfg_isel),
        .irq_src(irq_src), .irq_en(irq_en), .irq_cont(irq_cont), .irq_late(irq_late),
        .irq_clr(irq_clr), .ovf_clr(ovf_clr), .samp_chan(samp_chan), .samp_data(samp_data),
        .result_bus(result_bus), .irq_flag(irq_flag), .irq_pulse(irq_pulse),
        .ovf_flag(ovf_flag), .busy(busy), .busy_slot(busy_slot)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // monitor: log each conversion start and count line pulses
    int   start_cnt = 0;
    logic [3:0] start_log [0:255];
    logic prev_busy = 1'b0;
    int   pulse_cnt0 = 0;
    always @(negedge clk) begin
        if (busy && !prev_busy) begin
            if (start_cnt < 256) start_log[start_cnt] = busy_slot;
            start_cnt = start_cnt + 1;
        end
        prev_busy = busy;
        if (irq_pulse[0]) pulse_cnt0 = pulse_cnt0 + 1;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run hung, act=%0d exp=<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext(input int idx);
        ext_trig[idx] = 1'b1;
        step(1);
        ext_trig = '0;
    endtask

    task automatic wait_idle();
        int quiet;
        quiet = 0;
        for (int k = 0; k < 5000 && quiet < 3; k++) begin
            step(1);
            if (!busy) quiet = quiet + 1; else quiet = 0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic cfg_default();
        for (int i = 0; i < 16; i++) begin
            b_chan[i] = 4'(i);
            b_acq[i]  = 9'd14;
            b_tsel[i] = 3'd7;
            b_isel[i] = 2'd0;
        end
        for (int l = 0; l < 4; l++) b_src[l] = 4'd0;
        irq_en = '0; irq_cont = '0; irq_late = 1'b1;
    endtask

    // vector table: slot[15:12], channel[11:8], acquisition[7:0]
    localparam logic [15:0] VEC [6] = '{16'h030E, 16'h570E, 16'h9114,
                                        16'hFC1E, 16'h700E, 16'h2F11};

    initial begin
        int base, L, mism;
        cfg_default();
        do_reset();

        // R11 reset state
        chk(busy == 1'b0, "R11 busy", int'(busy), 0);
        chk(irq_flag == '0 && irq_pulse == '0, "R11 irq", int'(irq_flag), 0);
        chk(ovf_flag == '0, "R11 ovf", int'(ovf_flag), 0);
        chk(result_bus == '0, "R11 results", int'(result_bus[11:0]), 0);

        // R1/R2/R9 vector walk
        for (int v = 0; v < 6; v++) begin
            logic [3:0] s, ch;
            int a;
            s  = VEC[v][15:12];
            ch = VEC[v][11:8];
            a  = int'(VEC[v][7:0]);
            for (int i = 0; i < 16; i++) b_tsel[i] = 3'd7;
            b_tsel[s] = 3'd0; b_chan[s] = ch; b_acq[s] = 9'(a);
            step(1);
            base = start_cnt;
            L = a + CONV + 3;
            pulse_ext(0);
            step(1);
            chk(busy && busy_slot == s, "R9 busy slot", int'(busy_slot), int'(s));
            step(L - 3);
            chk(result_bus[s*12 +: 12] == 12'd0, "R1 result early", int'(result_bus[s*12 +: 12]), 0);
            step(1);
            chk(result_bus[s*12 +: 12] == fval(ch), "R1 result due", int'(result_bus[s*12 +: 12]), int'(fval(ch)));
            wait_idle();
            chk(start_cnt - base == 1, "R2 only selected slot ran", start_cnt - base, 1);
        end

        // R4: last started slot is 2, trigger 9 and 1 together -> 9 then 1
        for (int i = 0; i < 16; i++) b_tsel[i] = 3'd7;
        b_tsel[9] = 3'd0; b_tsel[1] = 3'd0;
        step(1);
        base = start_cnt;
        pulse_ext(0);
        wait_idle();
        chk(start_cnt - base == 2 && start_log[base] == 4'd9 && start_log[base+1] == 4'd1,
            "R4 order after last", int'(start_log[base]), 9);

        // R4: all 16 together after reset -> 0..15
        cfg_default();
        do_reset();
        for (int i = 0; i < 16; i++) b_tsel[i] = 3'd0;
        step(1);
        base = start_cnt;
        pulse_ext(0);
        wait_idle();
        mism = 0;
        for (int k = 0; k < 16; k++) if (start_log[base+k] != 4'(k)) mism++;
        chk(start_cnt - base == 16 && mism == 0, "R4 all slots in order", mism, 0);
        mism = 0;
        for (int i = 0; i < 16; i++) if (result_bus[i*12 +: 12] != fval(4'(i))) mism++;
        chk(mism == 0, "R1 all results", mism, 0);

        // R3 overflow while slot 4 is converting
        cfg_default();
        do_reset();
        b_tsel[4] = 3'd1; b_tsel[3] = 3'd0;
        step(1);
        base = start_cnt;
        pulse_ext(1);
        step(4);
        pulse_ext(0);
        step(2);
        pulse_ext(0);
        chk(ovf_flag == 16'h0008, "R3 overflow flag", int'(ovf_flag), 8);
        wait_idle();
        chk(start_cnt - base == 2 && start_log[base+1] == 4'd3, "R3 single conversion",
            start_cnt - base, 2);
        chk(ovf_flag == 16'h0008, "R3 flag sticky", int'(ovf_flag), 8);
        ovf_clr = 16'h0008;
        step(1);
        ovf_clr = '0;
        chk(ovf_flag == '0, "R3 overflow clear", int'(ovf_flag), 0);

        // R5/R6/R7/R8 interrupt line 0 on slot 6
        cfg_default();
        do_reset();
        b_tsel[6] = 3'd0; b_src[0] = 4'd6; irq_en = 4'b0001; irq_late = 1'b1;
        step(1);
        base = pulse_cnt0;
        L = 14 + CONV + 3;
        pulse_ext(0);
        step(L - 2);
        chk(irq_flag[0] == 1'b0, "R7 late flag not early", int'(irq_flag[0]), 0);
        step(1);
        chk(irq_flag[0] == 1'b1, "R5 late flag due", int'(irq_flag[0]), 1);
        wait_idle();
        pulse_ext(0);
        wait_idle();
        chk(pulse_cnt0 - base == 1, "R6 no refire while flag set", pulse_cnt0 - base, 1);
        irq_clr = 4'b1110;
        step(1);
        irq_clr = '0;
        chk(irq_flag[0] == 1'b1, "R8 zero bit keeps flag", int'(irq_flag[0]), 1);
        irq_clr = 4'b0001;
        step(1);
        irq_clr = '0;
        chk(irq_flag[0] == 1'b0, "R8 one bit clears flag", int'(irq_flag[0]), 0);
        irq_cont = 4'b0001;
        base = pulse_cnt0;
        pulse_ext(0);
        wait_idle();
        pulse_ext(0);
        wait_idle();
        chk(pulse_cnt0 - base == 2, "R6 continuous refires", pulse_cnt0 - base, 2);
        irq_cont = '0; irq_late = 1'b0;
        irq_clr = 4'b0001;
        step(1);
        irq_clr = '0;
        pulse_ext(0);
        step(14 + 1);
        chk(irq_flag[0] == 1'b0, "R7 early flag not yet", int'(irq_flag[0]), 0);
        step(1);
        chk(irq_flag[0] == 1'b1, "R7 early flag due", int'(irq_flag[0]), 1);
        wait_idle();

        // R10 continuous chain, R2 internal triggers
        cfg_default();
        do_reset();
        b_tsel[0] = 3'd0; b_isel[0] = 2'd2;
        for (int i = 1; i < 16; i++) b_isel[i] = 2'd1;
        b_src[0] = 4'd0; b_src[1] = 4'd15;
        irq_en = 4'b0011; irq_cont = 4'b0011; irq_late = 1'b1;
        step(1);
        base = start_cnt;
        pulse_ext(0);
        for (int k = 0; k < 5000 && (start_cnt - base) < 20; k++) step(1);
        b_isel[0] = 2'd0;
        wait_idle();
        chk(start_cnt - base == 32, "R10 chain stops after round", start_cnt - base, 32);
        mism = 0;
        for (int k = 0; k < 32; k++) if (start_log[base+k] != 4'(k % 16)) mism++;
        chk(mism == 0, "R10 R2 chained order", mism, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule